// File: doc/BRIEF.md
# Edge-Latched Interrupt Router

This block gathers level signals from a handful of on-board event sources, such as counter terminal-count outputs or a conversion-done flag. Each source first passes through a two-flop synchronizer. A low-to-high transition on a source sets a sticky pending bit. The pending bits, filtered by a per-source mask, are ORed into a single request. That request is driven onto exactly one of eight host interrupt lines, chosen by a 3-bit routing code.

A global enable gates the routing. While the enable is 0, every line stays inactive whatever the routing code says. Host software collects the pending bits with a read strobe. The strobe captures the pending word into a read-data register and acknowledges every bit it returned. An edge that arrives in the same cycle as the read is kept for the next read.

Top module: `edge_irq_router`

## Requirements
- R1: After reset, all interrupt lines are 0, the read data is 0, the global enable is 0, the routing code is 000 and every mask bit is 1.
- R2: A 0-to-1 transition on `src_lvl[i]` sets pending bit i. The bit is set three clock edges after the input changes: two synchronizer stages plus the pending register.
- R3: A source held high, or falling from 1 to 0, sets no pending bit. Only rising transitions are recorded.
- R4: A one-cycle `stat_rd` pulse loads `stat_q` with the pending word at that clock edge and clears every pending bit that was returned. `stat_q` holds its value until the next read.
- R5: A rising edge detected in the same cycle as `stat_rd` leaves its pending bit set after the read, so no event is lost.
- R6: While the global enable is 0, all eight lines are 0 regardless of the routing code and of pending bits. Pending bits still latch.
- R7: Routing code k drives output bit `irq_lines[k]`. The codes map to host lines as follows: 0 to IRQ3, 1 to IRQ4, 2 to IRQ5, 3 to IRQ10, 4 to IRQ6, 5 to IRQ7, 6 to IRQ11 and 7 to IRQ15.
- R8: The request is the OR of (pending AND mask). A masked source latches its pending bit but raises no line.
- R9: At most one interrupt line is active in any cycle.
- R10: The lines are registered. A change in pending bits or in configuration reaches `irq_lines` one clock edge after it is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Asynchronous source levels |
| cfg_wr | input | 1 | Writes enable, routing code and mask |
| cfg_en | input | 1 | Global enable value to write |
| cfg_sel | input | 3 | Routing code to write |
| cfg_mask | input | NUM_SRC | Per-source mask to write (1 = enabled) |
| stat_rd | input | 1 | Read-and-acknowledge strobe |
| stat_q | output | NUM_SRC | Pending word captured by the last read |
| irq_lines | output | 8 | One-of-eight interrupt lines |

## Verification
The bench sweeps all eight routing codes, with the enable both on and off, and checks the exact line bit. A decoder with swapped codes would light the wrong line, and a missing enable gate would raise a line while disabled. It holds a source high across a read and then drops it. A level-sensitive latch would show up here as a bit set again on the second read. It lines up a new edge with the read strobe in the same cycle. A design that cleared without ORing in the new edge would lose that event. It also checks the mask and the one-edge latency from a configuration write to the lines, which catch a mask that is ignored and a register stage added or missing.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SEL_W     = 3;
  localparam int NUM_LINES = 1 << SEL_W;
  typedef logic [SEL_W-1:0]     sel_t;
  typedef logic [NUM_LINES-1:0] lines_t;

  function automatic lines_t sel_decode(input sel_t code);
    lines_t v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= lvl;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] rise,
  input  logic               rd,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] rd_q
);
  logic [NUM_SRC-1:0] pend_n;

  always_comb begin
    pend_n = (rd ? '0 : pend) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      rd_q <= '0;
    end else begin
      pend <= pend_n;
      if (rd) rd_q <= pend;
    end
  end
endmodule

// File: rtl/irq_line_route.sv
module irq_line_route
  import irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  sel_t   sel,
  input  logic   req,
  output lines_t lines
);
  lines_t lines_n;

  always_comb begin
    lines_n = '0;
    if (en && req) lines_n = sel_decode(sel);
  end

  always_ff @(posedge clk) begin
    if (rst) lines <= '0;
    else     lines <= lines_n;
  end
endmodule

// File: rtl/edge_irq_router.sv
module edge_irq_router
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               cfg_wr,
  input  logic               cfg_en,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_mask,
  input  logic               stat_rd,
  output logic [NUM_SRC-1:0] stat_q,
  output logic [NUM_LINES-1:0] irq_lines
);
  logic               en_q;
  sel_t               sel_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] pend;
  logic               req;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      mask_q <= '1;
    end else if (cfg_wr) begin
      en_q   <= cfg_en;
      sel_q  <= cfg_sel;
      mask_q <= cfg_mask;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_src_sync u_sync (
      .clk  (clk),
      .rst  (rst),
      .lvl  (src_lvl[g]),
      .rise (rise[g])
    );
  end

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .rise (rise),
    .rd   (stat_rd),
    .pend (pend),
    .rd_q (stat_q)
  );

  assign req = |(pend & mask_q);

  irq_line_route u_route (
    .clk   (clk),
    .rst   (rst),
    .en    (en_q),
    .sel   (sel_q),
    .req   (req),
    .lines (irq_lines)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               stat_rd,
  input logic [NUM_SRC-1:0] stat_q,
  input lines_t             irq_lines,
  input logic               en_q,
  input sel_t               sel_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] rise
);
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_lines)); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> irq_lines == '0); // R6
  AST_ROUTE_LINE: assert property (@(posedge clk) disable iff (rst)
    $past(en_q && |(pend & mask_q)) |-> irq_lines[$past(sel_q)]); // R7
  AST_NO_REQ_NO_LINE: assert property (@(posedge clk) disable iff (rst)
    !$past(|(pend & mask_q)) |-> irq_lines == '0); // R8
  AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (pend & $past(rise)) == $past(rise)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> (pend & ~$past(rise)) == '0); // R4
  AST_READ_DATA: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> stat_q == $past(pend)); // R4
endmodule

bind edge_irq_router irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stat_rd   (stat_rd),
  .stat_q    (stat_q),
  .irq_lines (irq_lines),
  .en_q      (en_q),
  .sel_q     (sel_q),
  .mask_q    (mask_q),
  .pend      (pend),
  .rise      (rise)
);

// File: tb/tb_edge_irq_router.sv
module tb_edge_irq_router;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_lvl = '0;
  logic          cfg_wr = 1'b0;
  logic          cfg_en = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [NS-1:0] cfg_mask = '1;
  logic          stat_rd = 1'b0;
  logic [NS-1:0] stat_q;
  logic [7:0]    irq_lines;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  edge_irq_router #(.NUM_SRC(NS)) dut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask),
    .stat_rd(stat_rd), .stat_q(stat_q), .irq_lines(irq_lines)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_cfg(input logic en, input logic [2:0] sel, input logic [NS-1:0] m);
    cfg_wr = 1'b1; cfg_en = en; cfg_sel = sel; cfg_mask = m;
    cyc(1);
    cfg_wr = 1'b0;
    cyc(1);
  endtask

  task automatic pulse(input int i);
    src_lvl[i] = 1'b1;
    cyc(4);
    src_lvl[i] = 1'b0;
    cyc(3);
  endtask

  task automatic do_read(input string req, input logic [NS-1:0] exp);
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    chk(req, 32'(stat_q), 32'(exp));
    cyc(1);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    chk("R1 lines", 32'(irq_lines), 0);
    chk("R1 stat", 32'(stat_q), 0);
    pulse(0);
    chk("R1 enable default off", 32'(irq_lines), 0);
    do_read("R1 mask default on / R2", 4'b0001);

    // R7 R2 R4 R9: every routing code with enable on
    for (int s = 0; s < 8; s++) begin
      write_cfg(1'b1, 3'(s), '1);
      chk("R7 idle", 32'(irq_lines), 0);
      pulse(s % NS);
      chk("R7 routed line", 32'(irq_lines), 32'(8'(1) << s));
      do_read("R2 pending bit", 4'(1 << (s % NS)));
      chk("R4 ack drops line", 32'(irq_lines), 0);
      do_read("R4 cleared", 4'b0000);
    end

    // R6: enable off, every code
    for (int s = 0; s < 8; s++) begin
      write_cfg(1'b0, 3'(s), '1);
      pulse((s + 1) % NS);
      chk("R6 disabled lines", 32'(irq_lines), 0);
      do_read("R6 still latches", 4'(1 << ((s + 1) % NS)));
    end

    // R3: held level and falling edge set nothing
    src_lvl[2] = 1'b1;
    cyc(5);
    do_read("R3 first rise", 4'b0100);
    cyc(10);
    do_read("R3 held high", 4'b0000);
    src_lvl[2] = 1'b0;
    cyc(6);
    do_read("R3 falling", 4'b0000);

    // R8: mask
    write_cfg(1'b1, 3'd2, 4'b1110);
    pulse(0);
    chk("R8 masked no line", 32'(irq_lines), 0);
    pulse(1);
    chk("R8 unmasked line", 32'(irq_lines), 32'h04);
    do_read("R8 both latched", 4'b0011);

    // R5: edge coincident with read
    write_cfg(1'b1, 3'd5, '1);
    pulse(1);
    src_lvl[0] = 1'b1;   // rise seen by pending at third edge
    cyc(2);
    stat_rd = 1'b1;
    cyc(1);
    stat_rd = 1'b0;
    chk("R5 read old word", 32'(stat_q), 32'h2);
    cyc(1);
    chk("R5 line stays", 32'(irq_lines), 32'h20);
    src_lvl[0] = 1'b0;
    do_read("R5 edge kept", 4'b0001);

    // R10: config to line latency
    write_cfg(1'b0, 3'd3, '1);
    pulse(3);
    cfg_wr = 1'b1; cfg_en = 1'b1; cfg_sel = 3'd3; cfg_mask = '1;
    cyc(1);
    cfg_wr = 1'b0;
    chk("R10 one edge after write", 32'(irq_lines), 0);
    cyc(1);
    chk("R10 two edges after write", 32'(irq_lines), 32'h08);
    do_read("R10 drain", 4'b1000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule